// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

A single timer channel built for waveform generation. One up-counter, shared by two outputs, counts the ticks of a selected prescaled clock source and returns to zero when it reaches the period register. Output A has its own duty compare register and output B has another. Each output changes level through programmable actions, not through a fixed duty comparator. A duty compare event, a period compare event and a software trigger can each set, clear or toggle the output, or leave it alone.

Software first writes the mode word and the three compare registers. It then issues a command that enables the clock and raises a software trigger. The trigger zeroes the counter and places both outputs at their starting levels, and this is how a new configuration takes effect. With normal polarity an output is set on the period compare and cleared on its duty compare. With inverted polarity these two actions are swapped. A duty of zero or a duty equal to the period is produced by setting both compare actions to none. The output then holds the level that the trigger gave it.

Top module: `wave_timer_pair`

## Requirements
- R1: After reset both outputs are low, the counter reads 0, all registers are 0 and the clock is off, so source ticks do not advance the counter.
- R2: The counter advances by one only in a cycle where the clock is on and the source chosen by mode bits [2:0] pulses. Pulses on the other sources are ignored.
- R3: On a counting tick where the counter equals the period register (address 3), the counter goes to 0 instead of incrementing.
- R4: Output A applies its duty action (mode bits [4:3]) on a counting tick where the counter equals register A (address 1). It applies its period action (mode bits [6:5]) on a counting tick where the counter equals the period register. The action codes are 00 none, 01 set, 10 clear and 11 toggle.
- R5: Output B behaves the same way, using register B (address 2), duty action bits [10:9] and period action bits [12:11].
- R6: When the duty match and the period match occur on the same tick, only the period action is applied.
- R7: A command write (address 4) with bit 2 set zeroes the counter on the next edge. It applies A's trigger action (bits [8:7]) and B's trigger action (bits [14:13]), and these take priority over any compare event in that cycle.
- R8: Command bit 0 turns the clock on and bit 1 turns it off, and bit 1 wins when both are set. While the clock is off, the counter and both outputs hold.
- R9: A clock-select value with no matching source input (at or above the number of sources) never advances the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0 mode, 1 duty A, 2 duty B, 3 period, 4 command |
| wrData | input | WR_W | Write data |
| srcTick | input | NUM_SRC | Enable pulses, one per prescaled clock source |
| outA | output | 1 | Waveform output A |
| outB | output | 1 | Waveform output B |
| cntVal | output | CNT_W | Current counter value |

## Verification
The hardest cases to reach are those where events coincide on a single edge. One is a duty match and a period match on the same counting tick. Another is a software trigger arriving exactly when a compare would fire. A third is a clock-off command arriving while ticks are still pulsing. Directed phases set a duty register equal to the period, and issue triggers and disable commands on cycles where the counter sits on a compare value. A long random phase then mixes small period and duty values, random mode words, random tick patterns and random commands, so these collisions recur many times under varied action codes.

// File: rtl/wtp_pkg.sv
package wtp_pkg;

  localparam int SEL_W  = 3;
  localparam int MODE_W = 15;
  localparam int NUM_OUT = 2;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_DA   = 3'd1;
  localparam logic [2:0] ADDR_DB   = 3'd2;
  localparam logic [2:0] ADDR_PER  = 3'd3;
  localparam logic [2:0] ADDR_CMD  = 3'd4;

  localparam int CMD_ON  = 0;
  localparam int CMD_OFF = 1;
  localparam int CMD_TRG = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic count;
    logic swTrig;
  } strobe_t;

  typedef struct packed {
    act_e cmpA;
    act_e perA;
    act_e swA;
    act_e cmpB;
    act_e perB;
    act_e swB;
  } actCfg_t;

  function automatic logic applyAct(input act_e a, input logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/wtp_outcell.sv
module wtp_outcell
  import wtp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic swTrig,
  input  logic perHit,
  input  logic cmpHit,
  input  act_e swAct,
  input  act_e perAct,
  input  act_e cmpAct,
  output logic level
);

  // trigger over period over duty
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else if (swTrig) begin
      level <= applyAct(swAct, level);
    end else if (perHit) begin
      level <= applyAct(perAct, level);
    end else if (cmpHit) begin
      level <= applyAct(cmpAct, level);
    end
  end

endmodule

// File: rtl/wtp_ctrl.sv
module wtp_ctrl
  import wtp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 5,
  parameter int WR_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [WR_W-1:0]    wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output strobe_t            stb,
  output actCfg_t            acts,
  output logic [CNT_W-1:0]   dutyA,
  output logic [CNT_W-1:0]   dutyB,
  output logic [CNT_W-1:0]   perVal
);

  logic [MODE_W-1:0] modeReg;
  logic              clkOn;
  logic [SEL_W-1:0]  clkSel;
  logic              selTick;
  logic              cmdWr;

  assign cmdWr = wrEn && (wrAddr == ADDR_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= '0;
      dutyA   <= '0;
      dutyB   <= '0;
      perVal  <= '0;
      clkOn   <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_MODE: modeReg <= wrData[MODE_W-1:0];
        ADDR_DA:   dutyA   <= wrData[CNT_W-1:0];
        ADDR_DB:   dutyB   <= wrData[CNT_W-1:0];
        ADDR_PER:  perVal  <= wrData[CNT_W-1:0];
        ADDR_CMD: begin
          if (wrData[CMD_OFF])     clkOn <= 1'b0;
          else if (wrData[CMD_ON]) clkOn <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign clkSel = modeReg[2:0];

  // source mux; selects without a source give no tick
  always_comb begin
    selTick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (clkSel == SEL_W'(i)) selTick = srcTick[i];
    end
  end

  assign stb.count  = clkOn && selTick;
  assign stb.swTrig = cmdWr && wrData[CMD_TRG];

  assign acts.cmpA = act_e'(modeReg[4:3]);
  assign acts.perA = act_e'(modeReg[6:5]);
  assign acts.swA  = act_e'(modeReg[8:7]);
  assign acts.cmpB = act_e'(modeReg[10:9]);
  assign acts.perB = act_e'(modeReg[12:11]);
  assign acts.swB  = act_e'(modeReg[14:13]);

endmodule

// File: rtl/wtp_datapath.sv
module wtp_datapath
  import wtp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  actCfg_t          acts,
  input  logic [CNT_W-1:0] dutyA,
  input  logic [CNT_W-1:0] dutyB,
  input  logic [CNT_W-1:0] perVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             outA,
  output logic             outB
);

  logic [CNT_W-1:0]   cnt;
  logic               perMatch;
  logic [NUM_OUT-1:0] lvl;

  assign perMatch = (cnt == perVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (stb.swTrig) begin
      cnt <= '0;
    end else if (stb.count) begin
      cnt <= perMatch ? '0 : cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gOut
    logic [CNT_W-1:0] dutyVal;
    act_e cmpAct, perAct, swAct;
    assign dutyVal = (g == 0) ? dutyA     : dutyB;
    assign cmpAct  = (g == 0) ? acts.cmpA : acts.cmpB;
    assign perAct  = (g == 0) ? acts.perA : acts.perB;
    assign swAct   = (g == 0) ? acts.swA  : acts.swB;

    wtp_outcell uCell (
      .clk    (clk),
      .rst    (rst),
      .swTrig (stb.swTrig),
      .perHit (stb.count && perMatch),
      .cmpHit (stb.count && (cnt == dutyVal)),
      .swAct  (swAct),
      .perAct (perAct),
      .cmpAct (cmpAct),
      .level  (lvl[g])
    );
  end

  assign cntVal = cnt;
  assign outA   = lvl[0];
  assign outB   = lvl[1];

endmodule

// File: rtl/wave_timer_pair.sv
module wave_timer_pair
  import wtp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 5,
  parameter int WR_W    = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [WR_W-1:0]    wrData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               outA,
  output logic               outB,
  output logic [CNT_W-1:0]   cntVal
);

  strobe_t          stb;
  actCfg_t          acts;
  logic [CNT_W-1:0] dutyA, dutyB, perVal;

  wtp_ctrl #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .WR_W(WR_W)) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srcTick(srcTick), .stb(stb), .acts(acts),
    .dutyA(dutyA), .dutyB(dutyB), .perVal(perVal)
  );

  wtp_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .stb(stb), .acts(acts),
    .dutyA(dutyA), .dutyB(dutyB), .perVal(perVal),
    .cntVal(cntVal), .outA(outA), .outB(outB)
  );

endmodule

// File: rtl/wtp_checker.sv
module wtp_checker
  import wtp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input strobe_t          stb,
  input logic             clkOn,
  input logic [CNT_W-1:0] perVal,
  input logic [CNT_W-1:0] cntVal,
  input logic             outA,
  input logic             outB
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cntVal == '0 && !outA && !outB));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (stb.count && !stb.swTrig && cntVal != perVal)
      |=> cntVal == CNT_W'($past(cntVal) + 1'b1));

  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!stb.count && !stb.swTrig) |=> $stable(cntVal));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (stb.count && !stb.swTrig && cntVal == perVal) |=> cntVal == '0);

  a_r7_trigger_zero: assert property (@(posedge clk) disable iff (rst)
    stb.swTrig |=> cntVal == '0);

  a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
    (!clkOn && !stb.swTrig) |=> ($stable(cntVal) && $stable(outA) && $stable(outB)));

endmodule

bind wave_timer_pair wtp_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .stb(stb), .clkOn(uCtrl.clkOn),
  .perVal(perVal), .cntVal(cntVal), .outA(outA), .outB(outB)
);

// File: tb/tb_wave_timer_pair.sv
module tb_wave_timer_pair;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NSRC  = 5;
  localparam int WR_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wrEn = 1'b0;
  logic [2:0]       wrAddr = '0;
  logic [WR_W-1:0]  wrData = '0;
  logic [NSRC-1:0]  srcTick = '0;
  logic             outA, outB;
  logic [CNT_W-1:0] cntVal;

  int    nChecks = 0;
  int    nFail   = 0;
  bit    done    = 0;
  string curTag  = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_timer_pair #(.CNT_W(CNT_W), .NUM_SRC(NSRC)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srcTick(srcTick), .outA(outA), .outB(outB), .cntVal(cntVal)
  );

  // ---------------- reference model from the requirements ----------------
  logic [14:0]      mMode;
  logic [CNT_W-1:0] mDa, mDb, mPer, mCnt;
  logic             mOn, mA, mB;

  function automatic logic actOn(input logic [1:0] code, input logic cur);
    case (code)
      2'b01: return 1'b1;
      2'b10: return 1'b0;
      2'b11: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic nextLvl(input logic cur, input logic sw, input logic per,
                                   input logic cmp, input logic [1:0] swC,
                                   input logic [1:0] perC, input logic [1:0] cmpC);
    if (sw)  return actOn(swC, cur);
    if (per) return actOn(perC, cur);
    if (cmp) return actOn(cmpC, cur);
    return cur;
  endfunction

  function automatic logic pickTick(input logic [2:0] sel, input logic [NSRC-1:0] t);
    for (int i = 0; i < NSRC; i++) if (int'(sel) == i) return t[i];
    return 1'b0;
  endfunction

  function automatic logic [14:0] mkMode(input int sel, input int aCmp, input int aPer,
      input int aSw, input int bCmp, input int bPer, input int bSw);
    return {bSw[1:0], bPer[1:0], bCmp[1:0], aSw[1:0], aPer[1:0], aCmp[1:0], sel[2:0]};
  endfunction

  always @(posedge clk) begin
    logic sw, tk;
    if (rst) begin
      mMode <= '0; mDa <= '0; mDb <= '0; mPer <= '0; mCnt <= '0;
      mOn <= 1'b0; mA <= 1'b0; mB <= 1'b0;
    end else begin
      sw = wrEn && wrAddr == 3'd4 && wrData[2];
      tk = mOn && pickTick(mMode[2:0], srcTick);
      if (sw) mCnt <= '0;
      else if (tk) mCnt <= (mCnt == mPer) ? '0 : mCnt + 1'b1;
      mA <= nextLvl(mA, sw, tk && mCnt == mPer, tk && mCnt == mDa,
                    mMode[8:7], mMode[6:5], mMode[4:3]);
      mB <= nextLvl(mB, sw, tk && mCnt == mPer, tk && mCnt == mDb,
                    mMode[14:13], mMode[12:11], mMode[10:9]);
      if (wrEn) begin
        case (wrAddr)
          3'd0: mMode <= wrData[14:0];
          3'd1: mDa   <= wrData;
          3'd2: mDb   <= wrData;
          3'd3: mPer  <= wrData;
          3'd4: if (wrData[1]) mOn <= 1'b0; else if (wrData[0]) mOn <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking and driving ----------------
  task automatic checkNow();
    nChecks++;
    if (cntVal !== mCnt || outA !== mA || outB !== mB) begin
      nFail++;
      $display("FAIL %s: cnt=%0d exp %0d, outA=%b exp %b, outB=%b exp %b",
               curTag, cntVal, mCnt, outA, mA, outB, mB);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [WR_W-1:0] d,
                      input logic [NSRC-1:0] t);
    @(negedge clk);
    if (!rst) checkNow();
    wrEn = we; wrAddr = a; wrData = d; srcTick = t;
  endtask

  task automatic wr(input logic [2:0] a, input logic [WR_W-1:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic run(input int n, input logic [NSRC-1:0] t);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1: reset state and clock off
    repeat (3) @(negedge clk);
    rst = 1'b0;
    curTag = "R1";
    nChecks++;
    if (cntVal !== '0 || outA !== 1'b0 || outB !== 1'b0) begin
      nFail++;
      $display("FAIL R1: cnt=%0d A=%b B=%b exp 0 0 0", cntVal, outA, outB);
    end
    run(6, '1);

    // R2: only the selected source advances the counter
    curTag = "R2";
    wr(3'd3, 16'd100);
    wr(3'd0, {1'b0, mkMode(1, 0, 0, 0, 0, 0, 0)});
    wr(3'd4, 16'h0001);
    run(5, 5'b11101);
    run(5, 5'b00010);
    run(4, 5'b10110);

    // R4: output A normal polarity, R3 period wrap
    curTag = "R4";
    wr(3'd1, 16'd3);
    wr(3'd3, 16'd7);
    wr(3'd0, {1'b0, mkMode(0, 2, 1, 1, 0, 0, 0)});
    wr(3'd4, 16'h0005);
    run(20, 5'b00001);
    curTag = "R3";
    run(10, 5'b00001);

    // R5: output B inverted polarity, A toggling on period
    curTag = "R5";
    wr(3'd2, 16'd5);
    wr(3'd0, {1'b0, mkMode(0, 0, 3, 2, 1, 2, 2)});
    wr(3'd4, 16'h0004);
    run(24, 5'b00001);

    // R6: duty equal to period, period action wins
    curTag = "R6";
    wr(3'd1, 16'd7);
    wr(3'd2, 16'd7);
    wr(3'd0, {1'b0, mkMode(0, 1, 2, 1, 2, 1, 2)});
    wr(3'd4, 16'h0004);
    run(24, 5'b00001);

    // R7: trigger in the same cycle as a compare match
    curTag = "R7";
    wr(3'd1, 16'd2);
    wr(3'd0, {1'b0, mkMode(0, 3, 3, 2, 3, 3, 1)});
    wr(3'd4, 16'h0004);
    run(2, 5'b00001);
    step(1'b1, 3'd4, 16'h0004, 5'b00001);
    run(7, 5'b00001);
    step(1'b1, 3'd4, 16'h0004, 5'b00001);
    run(3, 5'b00001);

    // R8: disable holds; disable wins over enable
    curTag = "R8";
    wr(3'd4, 16'h0002);
    run(8, '1);
    wr(3'd4, 16'h0003);
    run(8, '1);
    wr(3'd4, 16'h0001);
    run(4, '1);

    // R9: select with no source never counts
    curTag = "R9";
    wr(3'd0, {1'b0, mkMode(6, 1, 2, 1, 1, 2, 1)});
    run(10, '1);
    wr(3'd0, {1'b0, mkMode(7, 1, 2, 1, 1, 2, 1)});
    run(10, '1);

    // random phase covering R3, R4, R5, R6, R7, R8
    curTag = "R4 random";
    for (int i = 0; i < 4000; i++) begin
      logic [NSRC-1:0] t;
      int r;
      t = NSRC'($urandom);
      r = int'($urandom_range(0, 15));
      if (r == 0)      step(1'b1, 3'd0, 16'($urandom_range(0, 32767)) & 16'h7FF8 | 16'($urandom_range(0, 5)), t);
      else if (r == 1) step(1'b1, 3'd1, 16'($urandom_range(0, 12)), t);
      else if (r == 2) step(1'b1, 3'd2, 16'($urandom_range(0, 12)), t);
      else if (r == 3) step(1'b1, 3'd3, 16'($urandom_range(0, 10)), t);
      else if (r == 4) step(1'b1, 3'd4, 16'($urandom_range(0, 7)), t);
      else             step(1'b0, 3'd0, '0, t);
    end
    step(1'b0, 3'd0, '0, '0);
    step(1'b0, 3'd0, '0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule